// File: doc/BRIEF.md
# Clock-Synchronous Serial Receive Channel with FIFO

This block receives a serial bit stream clocked by an external serial clock and turns it into bytes for a host. Both serial lines enter the system clock domain through two-flop synchronizers. A rising serial clock edge is detected in that domain, and the data bit is sampled at that edge. Bits arrive least significant first. Eight bits make a byte, and each byte is written into a 16-entry receive FIFO.

The host uses a small register port with five registers. Reading the data register pops one byte. A status register holds a ready flag. The ready flag sets once the FIFO fill reaches a selectable trigger level. It also raises a one-cycle interrupt pulse when it goes from 0 to 1.

A byte that completes while the FIFO is full is dropped and sets a sticky overrun flag. While that flag is set, reception stops. It resumes only after software writes the flag to 0. Clearing the enable bit also stops reception.

Top module: `sync_rx_channel`

## Requirements
- R1: While CTRL[0] (enable) is 1 and no overrun is pending, the data line is sampled at each rising serial clock edge. The first bit sampled becomes bit 0 of the byte. After the eighth bit, the byte enters the FIFO.
- R2: The register addresses are 0 DATA, 1 STAT, 2 LINE, 3 COUNT and 4 CTRL. Reading DATA returns the oldest byte in bits [7:0] and removes it from the FIFO, so bytes leave in arrival order. COUNT[7:0] holds the number of bytes in the FIFO, which never exceeds 16.
- R3: A DATA read from an empty FIFO returns the byte from the most recent successful DATA read, and COUNT stays unchanged.
- R4: CTRL[2:1] selects the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. STAT[0] (ready) becomes 1 when COUNT reaches the trigger level.
- R5: Output rx_irq is high for exactly one cycle, in the cycle where STAT[0] changes from 0 to 1.
- R6: Writing 0 to STAT[0] clears it only when both of these hold: STAT has been read with STAT[0] = 1 since the last clear, and COUNT is below the trigger level. Otherwise STAT[0] stays 1.
- R7: When a byte completes while the FIFO holds 16 bytes, that byte is discarded and LINE[0] (overrun) becomes 1.
- R8: While LINE[0] is 1, no byte enters the FIFO. LINE[0] stays 1 until the host writes LINE with bit 0 = 0.
- R9: While CTRL[0] is 0, serial clock edges are ignored, and any partly received byte is dropped.
- R10: After reset, every register reads 0. STAT[1] (parity error) and STAT[2] (framing error) can only be cleared by writing 0. A write of 1 never sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_in | input | 1 | External serial clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data, sampled on the rising edge of sclk_in |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the side effects happen at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
A rising edge on sclk_in is seen after two synchronizer flops. The shifter registers the bit one cycle later. The FIFO count updates one cycle after that, and the ready flag and interrupt one cycle after the count. So COUNT reflects a finished byte within five clocks of the eighth serial rising edge, and STAT[0] and rx_irq within six. The bench holds each serial level for four clocks and waits ten clocks after each byte before it reads a register. Register reads are sampled one nanosecond after the falling edge that drives the strobe, so each pop or flag side effect is due at the next rising edge. The next read starts after that edge.

// File: rtl/sync_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial receive channel.
// Assumes a register data path of 16 bits and a 3-bit register address.
package sync_rx_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 3'd0,
        REG_STAT  = 3'd1,
        REG_LINE  = 3'd2,
        REG_COUNT = 3'd3,
        REG_CTRL  = 3'd4
    } reg_addr_e;

    // Maps the 2-bit trigger select field to a byte count.
    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd1;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd14;
        endcase
    endfunction
endpackage

// File: rtl/srx_sync_edge.sv
`timescale 1ns/1ps
// Brings the serial clock and data into the clk domain and detects the
// rising serial clock edge. Assumes each serial level lasts at least two clk
// cycles. The data bit is taken from the same synchronizer stage as the edge.
module srx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic rise,
    output logic bit_val
);
    logic [1:0] sclk_meta;
    logic [1:0] sdata_meta;
    logic       sclk_prev;

    // Two-flop synchronizers, plus one delayed copy of the clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_meta  <= '0;
            sdata_meta <= '0;
            sclk_prev  <= 1'b0;
        end else begin
            sclk_meta  <= {sclk_meta[0], sclk_in};
            sdata_meta <= {sdata_meta[0], sdata_in};
            sclk_prev  <= sclk_meta[1];
        end
    end

    assign rise    = sclk_meta[1] & ~sclk_prev;
    assign bit_val = sdata_meta[1];
endmodule

// File: rtl/srx_shifter.sv
`timescale 1ns/1ps
// Assembles serial bits, LSB first, into DATA_W-bit words.
// byte_valid pulses for one cycle with byte_data holding the finished word.
// When enable is low, edges are ignored and the bit counter returns to zero.
module srx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rise,
    input  logic              bit_val,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;

    // Shift in one bit per detected edge and flag each completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (!enable) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {bit_val, shreg[DATA_W-1:1]};
                if (bit_cnt == BIT_W'(DATA_W-1)) begin
                    bit_cnt    <= '0;
                    byte_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign byte_data = shreg;
endmodule

// File: rtl/srx_fifo.sv
`timescale 1ns/1ps
// Synchronous first-in first-out store with an occupancy count.
// Assumes the caller never pushes when full and never pops when empty.
module srx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy tracking with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/sync_rx_channel.sv
`timescale 1ns/1ps
// Clock-synchronous serial receive channel with a receive FIFO and host registers.
// Assumes DEPTH is at most 127, so the count fits the 8-bit count field.
// Host reads have side effects (pop, ready-flag qualification) at the clock edge.
module sync_rx_channel
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              rise, bit_val;
    logic              byte_valid;
    logic [DATA_W-1:0] byte_data;
    logic              push, pop;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fifo_count;
    logic              full, empty;
    logic [7:0]        count8;

    logic              rx_en_q;
    logic [1:0]        trig_sel_q;
    logic              ovr_q, rdy_q, rdy_seen_q, per_q, fer_q;
    logic [DATA_W-1:0] last_rd_q;
    logic              at_trig, rdy_clear, rdy_d;
    logic              wr_stat, wr_line, wr_ctrl, rd_stat, rd_data;
    logic              wdata_unused;

    srx_sync_edge sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .sdata_in (sdata_in),
        .rise     (rise),
        .bit_val  (bit_val)
    );

    srx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en_q & ~ovr_q),
        .rise       (rise),
        .bit_val    (bit_val),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    srx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (byte_data),
        .pop       (pop),
        .head      (head),
        .count     (fifo_count),
        .full      (full),
        .empty     (empty)
    );

    // Register strobe decode.
    assign wr_stat = reg_wr && (reg_addr == REG_STAT);
    assign wr_line = reg_wr && (reg_addr == REG_LINE);
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign rd_stat = reg_rd && (reg_addr == REG_STAT);
    assign rd_data = reg_rd && (reg_addr == REG_DATA);
    assign wdata_unused = ^reg_wdata[REG_W-1:3];

    assign push   = byte_valid & ~full;
    assign pop    = rd_data & ~empty;
    assign count8 = {{(8-CNT_W){1'b0}}, fifo_count};

    // Ready flag: sets at the trigger level; cleared only after a qualified 1-read then 0-write.
    assign at_trig   = (count8 >= trig_level(trig_sel_q));
    assign rdy_clear = wr_stat && !reg_wdata[0] && rdy_seen_q && !at_trig;
    assign rdy_d     = at_trig ? 1'b1 : (rdy_clear ? 1'b0 : rdy_q);

    // Control register, holding the enable bit and the trigger select field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q    <= 1'b0;
            trig_sel_q <= 2'd0;
        end else if (wr_ctrl) begin
            rx_en_q    <= reg_wdata[0];
            trig_sel_q <= reg_wdata[2:1];
        end
    end

    // Sticky overrun: set by a byte arriving while full, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (byte_valid && full) ovr_q <= 1'b1;
        else if (wr_line && !reg_wdata[0]) ovr_q <= 1'b0;
    end

    // Ready flag, its read-as-1 qualifier and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q      <= 1'b0;
            rdy_seen_q <= 1'b0;
            rx_irq     <= 1'b0;
        end else begin
            rdy_q  <= rdy_d;
            rx_irq <= rdy_d & ~rdy_q;
            if (rdy_clear)           rdy_seen_q <= 1'b0;
            else if (rd_stat && rdy_q) rdy_seen_q <= 1'b1;
        end
    end

    // Parity and framing flags: clear-only status bits, never set in this mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= 1'b0;
            fer_q <= 1'b0;
        end else if (wr_stat) begin
            per_q <= per_q & reg_wdata[1];
            fer_q <= fer_q & reg_wdata[2];
        end
    end

    // Holds the last popped byte for reads of an empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_rd_q <= '0;
        else if (pop) last_rd_q <= head;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_DATA:  reg_rdata = {{(REG_W-DATA_W){1'b0}}, (empty ? last_rd_q : head)};
            REG_STAT:  reg_rdata = {{(REG_W-3){1'b0}}, fer_q, per_q, rdy_q};
            REG_LINE:  reg_rdata = {{(REG_W-1){1'b0}}, ovr_q};
            REG_COUNT: reg_rdata = {{(REG_W-8){1'b0}}, count8};
            REG_CTRL:  reg_rdata = {{(REG_W-3){1'b0}}, trig_sel_q, rx_en_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sync_rx_channel_chk.sv
`timescale 1ns/1ps
// Property checker for sync_rx_channel, attached by bind below.
// Assumes the default register map from sync_rx_pkg.
module sync_rx_channel_chk
    import sync_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              ovr,
    input logic              rdy,
    input logic              irq,
    input logic              rx_en,
    input logic              byte_valid,
    input logic              push,
    input logic [1:0]        trig_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata
);
    logic line_clr;
    logic trig_met;
    assign line_clr = reg_wr && (reg_addr == REG_LINE) && !reg_wdata[0];
    assign trig_met = ({{(8-CNT_W){1'b0}}, fifo_count} >= trig_level(trig_sel));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R5
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> irq);

    // R5
    irq_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy && !$past(rdy)));

    // R6
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && trig_met) |=> rdy);

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && fifo_count == CNT_W'(DEPTH)) |=> ovr);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !line_clr) |=> ovr);

    // R8
    ovr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !push);

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !byte_valid);
endmodule

bind sync_rx_channel sync_rx_channel_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .ovr        (ovr_q),
    .rdy        (rdy_q),
    .irq        (rx_irq),
    .rx_en      (rx_en_q),
    .byte_valid (byte_valid),
    .push       (push),
    .trig_sel   (trig_sel_q),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata)
);

// File: tb/sync_rx_channel_tb_top.sv
`timescale 1ns/1ps
// Directed bench for sync_rx_channel: one task per scenario, each checking its results.
module sync_rx_channel_tb_top;
    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_LINE = 3'd2,
                           A_COUNT = 3'd3, A_CTRL = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        rx_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    sync_rx_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_irq    (rx_irq)
    );

    // Counts interrupt pulses.
    always @(posedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        sclk_in = 1'b0; sdata_in = b;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        host_read(A_COUNT, d); chk("R10 count after reset", d, 16'h0);
        host_read(A_STAT, d);  chk("R10 stat after reset", d, 16'h0);
        host_read(A_LINE, d);  chk("R10 line after reset", d, 16'h0);
        host_read(A_CTRL, d);  chk("R10 ctrl after reset", d, 16'h0);
        chk("R10 irq after reset", {15'd0, rx_irq}, 16'h0);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        int i0;
        host_write(A_CTRL, 16'h0001);
        i0 = irq_cnt;
        send_byte(8'hA5);
        host_read(A_COUNT, d); chk("R1 count after one byte", d, 16'h1);
        chk("R5 one irq pulse", 16'(irq_cnt - i0), 16'h1);
        host_read(A_STAT, d);  chk("R4 ready at level 1", d, 16'h1);
        host_read(A_DATA, d);  chk("R1 lsb-first byte", d, 16'h00A5);
        host_read(A_COUNT, d); chk("R2 count after pop", d, 16'h0);
        host_read(A_DATA, d);  chk("R3 empty read repeats", d, 16'h00A5);
        host_read(A_COUNT, d); chk("R3 empty read count", d, 16'h0);
        host_write(A_STAT, 16'h0000);
        host_read(A_STAT, d);  chk("R6 qualified clear", d, 16'h0);
    endtask

    task automatic t_trigger();
        logic [15:0] d;
        int i0;
        host_write(A_CTRL, 16'h0003);
        i0 = irq_cnt;
        for (int k = 0; k < 3; k++) send_byte(8'hC1 + 8'(k));
        host_read(A_STAT, d);  chk("R4 below level 4", d, 16'h0);
        send_byte(8'hC4);
        host_read(A_COUNT, d); chk("R4 count at level", d, 16'h4);
        chk("R5 irq at level 4", 16'(irq_cnt - i0), 16'h1);
        host_read(A_DATA, d);  chk("R2 first out", d, 16'h00C1);
        host_write(A_STAT, 16'h0000);
        host_read(A_STAT, d);  chk("R6 clear without read-as-1 ignored", d, 16'h1);
        host_write(A_STAT, 16'h0000);
        host_read(A_STAT, d);  chk("R6 clear after read-as-1", d, 16'h0);
        for (int k = 1; k < 4; k++) begin
            host_read(A_DATA, d); chk("R2 order", d, 16'h00C1 + 16'(k));
        end
    endtask

    task automatic t_overrun();
        logic [15:0] d;
        host_write(A_CTRL, 16'h0007);
        for (int k = 0; k < 16; k++) send_byte(8'h10 + 8'(k));
        host_read(A_COUNT, d); chk("R2 full count", d, 16'd16);
        host_read(A_LINE, d);  chk("R7 no overrun when just full", d, 16'h0);
        send_byte(8'hEE);
        host_read(A_COUNT, d); chk("R7 count stays full", d, 16'd16);
        host_read(A_LINE, d);  chk("R7 overrun set", d, 16'h1);
        host_read(A_DATA, d);  chk("R7 oldest kept", d, 16'h0010);
        send_byte(8'h77);
        host_read(A_COUNT, d); chk("R8 blocked while overrun", d, 16'd15);
        host_write(A_LINE, 16'h0001);
        host_read(A_LINE, d);  chk("R8 write 1 keeps overrun", d, 16'h1);
        host_write(A_LINE, 16'h0000);
        host_read(A_LINE, d);  chk("R8 overrun cleared", d, 16'h0);
        send_byte(8'h3C);
        host_read(A_COUNT, d); chk("R8 resumes after clear", d, 16'd16);
        for (int k = 1; k < 16; k++) begin
            host_read(A_DATA, d); chk("R7 order after overrun", d, 16'h0010 + 16'(k));
        end
        host_read(A_DATA, d);  chk("R7 discarded bytes absent", d, 16'h003C);
        host_read(A_STAT, d);  chk("R4 ready at level 14", d, 16'h1);
        host_write(A_STAT, 16'h0000);
        host_read(A_STAT, d);  chk("R6 clear after drain", d, 16'h0);
    endtask

    task automatic t_disable();
        logic [15:0] d;
        host_write(A_CTRL, 16'h0001);
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        host_write(A_CTRL, 16'h0000);
        for (int k = 0; k < 8; k++) send_bit(k[0]);
        repeat (10) @(negedge clk);
        host_read(A_COUNT, d); chk("R9 edges ignored", d, 16'h0);
        host_write(A_CTRL, 16'h0001);
        send_byte(8'h5A);
        host_read(A_COUNT, d); chk("R9 count after re-enable", d, 16'h1);
        host_read(A_DATA, d);  chk("R9 partial byte dropped", d, 16'h005A);
        host_read(A_STAT, d);
        host_write(A_STAT, 16'h0000);
    endtask

    task automatic t_errflags();
        logic [15:0] d;
        host_write(A_STAT, 16'h0006);
        host_read(A_STAT, d);  chk("R10 error flags not set by write", d, 16'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_trigger();
        t_overrun();
        t_disable();
        t_errflags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule